// File: doc/BRIEF.md
# Access-Checked Serial Bridge Target

This block sits at the far end of a byte-wide link from a user-side bridge. It collects the link's byte beats into 32-bit words, removes the XOR mask the sender applied, and checks every access address against a small table of address windows. An access that hits an enabled window, while the user side is not globally blocked, becomes one cycle on a downstream 32-bit memory-mapped master that honours a wait request. An access that hits no window is dropped without a trace. A dropped read hands back zeros. Either way the link handshake always finishes, so the user side cannot hang.

A second, word-wide configuration port belongs to a security controller. Through it the controller sets the windows, the global block bit, the encryption enable, the two 48-bit mask keys and a 64-bit board key. The port also holds a ratchet counter. Any write to the ratchet moves it up by one. It stops at a ceiling, and only a reset brings it back down. After reset nothing is allowed until the controller opens a window and clears the block bit.

Top module: `slt_gate`

## Requirements
- R1: A write starts with `up_start`=1, `up_wr`=1 and the address in one cycle. Four data bytes follow on `up_wbyte` in the next four cycles, least significant byte first. If the write is allowed, a single downstream write carries that address and the rebuilt word. `up_ack` pulses for one cycle 6+w cycles after the start cycle, where w is the number of cycles `dn_wait` holds the request.
- R2: A read starts with `up_start`=1 and `up_wr`=0. If it is allowed, a single downstream read is made. `up_rvalid` then carries the 32-bit result as four bytes on `up_rbyte`, least significant first, beginning w+2 cycles after the start cycle. `up_ack` pulses in the cycle after the last byte, and never in the same cycle as `up_rvalid`.
- R3: There are four windows. Window i has its low word at config offset 8+2i, with bit 31 as the enable and bits 23:0 as the low bound. Its high word is at offset 9+2i, with bits 23:0 as the high bound. An address is allowed when some enabled window has low ≤ address ≤ high, both bounds included.
- R4: A denied access issues no downstream cycle. A denied read returns four zero bytes. A denied access keeps the zero-wait handshake timing: for a read the bytes start 2 cycles after start, and for a write the ack comes 6 cycles after start.
- R5: Bit 0 of config offset 0 is the global block. While it is 1, every user access is denied.
- R6: Bit 1 of config offset 0 enables encryption. The mask is built as {P[47:44],C[47:44],P[43:40],C[43:40],P[7:4],C[7:4],P[3:0],C[3:0]}, where P is the pass key and C is the card key. When encryption is enabled, downstream write data is the link word XOR the mask, and the read word sent on the link is the downstream data XOR the mask.
- R7: The ratchet sits at offset 1. A write there raises it by one whatever the data, and it stops at 8. A read returns its value in bits 3:0. It never goes down except through reset.
- R8: The board key is 64 bits, with the low word at offset 2 and the high word at offset 3. The pass key is at offsets 4 (bits 31:0) and 5 (bits 47:32, held in data bits 15:0). The card key is at offsets 6 and 7 in the same layout. Every config register reads back what was written. Read data appears on `cfg_rdata` in the cycle after `cfg_rd`.
- R9: After reset the block bit is 1, encryption is off, every window is disabled with zero bounds, and every key and the ratchet read 0.
- R10: While `dn_wait` is 1, the downstream request, address and direction hold steady. The read data is taken in the cycle `dn_wait` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_start | input | 1 | Starts a link transaction when the block is idle |
| up_wr | input | 1 | Direction of the transaction, 1 for write |
| up_addr | input | 24 | Transaction address, sampled with up_start |
| up_wbyte | input | 8 | Write data byte beat |
| up_rvalid | output | 1 | Read byte beat valid |
| up_rbyte | output | 8 | Read data byte beat |
| up_ack | output | 1 | One-cycle end-of-transaction pulse |
| up_busy | output | 1 | A transaction is in progress |
| dn_addr | output | 24 | Downstream address |
| dn_read | output | 1 | Downstream read request |
| dn_write | output | 1 | Downstream write request |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data |
| dn_wait | input | 1 | Downstream wait request |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, one cycle after cfg_rd |

## Verification
Every result has a fixed cycle, counted from the start cycle. The first read byte comes w+2 cycles after start, the read ack 4 cycles after the first byte, and the write ack 6+w cycles after start, where a denied access counts as w=0. Config read data arrives one cycle after the strobe. The bench counts falling edges from the start cycle and compares the exact cycle of each event, not just whether it arrived. A per-clock monitor flags any downstream request that the bench's own window model did not predict. The downstream stub applies a chosen number of wait cycles, so the hold behaviour and the shifted timing are both exercised.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int DATA_W   = 32;
  localparam int KEY_W    = 48;
  localparam int BEAT_W   = 8;
  localparam int BEATS    = DATA_W / BEAT_W;
  localparam int WIN_BASE = 8;

  localparam int OFS_CTRL    = 0;
  localparam int OFS_RATCHET = 1;
  localparam int OFS_BKEY_LO = 2;
  localparam int OFS_BKEY_HI = 3;
  localparam int OFS_PASS_LO = 4;
  localparam int OFS_PASS_HI = 5;
  localparam int OFS_CARD_LO = 6;
  localparam int OFS_CARD_HI = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATHER,
    ST_ISSUE,
    ST_RESP,
    ST_ACK
  } link_st_e;

  // interleave nibbles of the two keys into a word-wide XOR mask
  function automatic logic [DATA_W-1:0] mix_mask(input logic [KEY_W-1:0] p,
                                                 input logic [KEY_W-1:0] c);
    return {p[47:44], c[47:44], p[43:40], c[43:40],
            p[7:4],   c[7:4],   p[3:0],   c[3:0]};
  endfunction
endpackage

// File: rtl/slt_window_match.sv
module slt_window_match #(
  parameter int ADDR_W = 24,
  parameter int N_WIN  = 4
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [N_WIN-1:0][ADDR_W-1:0]  win_lo,
  input  logic [N_WIN-1:0][ADDR_W-1:0]  win_hi,
  input  logic [N_WIN-1:0]              win_vld,
  output logic                          hit
);
  logic [N_WIN-1:0] in_win;

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    assign in_win[i] = win_vld[i] && (addr >= win_lo[i]) && (addr <= win_hi[i]);
  end

  assign hit = |in_win;
endmodule

// File: rtl/slt_cfg_regs.sv
module slt_cfg_regs
  import slt_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int N_WIN       = 4,
  parameter int RATCHET_MAX = 8,
  parameter int CFG_AW      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic                          cfg_wr,
  input  logic                          cfg_rd,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic [DATA_W-1:0]             cfg_rdata,
  output logic                          inhibit,
  output logic                          enc_en,
  output logic [KEY_W-1:0]              pass_key,
  output logic [KEY_W-1:0]              card_key,
  output logic [N_WIN-1:0][ADDR_W-1:0]  win_lo,
  output logic [N_WIN-1:0][ADDR_W-1:0]  win_hi,
  output logic [N_WIN-1:0]              win_vld
);
  localparam int RW    = $clog2(RATCHET_MAX + 1);
  localparam int KHI_W = KEY_W - DATA_W;

  logic                         inh_q, inh_d;
  logic                         enc_q, enc_d;
  logic [RW-1:0]                rat_q, rat_d;
  logic [DATA_W-1:0]            bk_lo_q, bk_lo_d, bk_hi_q, bk_hi_d;
  logic [KEY_W-1:0]             pk_q, pk_d, ck_q, ck_d;
  logic [N_WIN-1:0][ADDR_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [N_WIN-1:0]             vld_q, vld_d;
  logic [DATA_W-1:0]            rdata_q, rd_val;

  function automatic logic hit_ofs(input logic [CFG_AW-1:0] a, input int ofs);
    return a == CFG_AW'(ofs);
  endfunction

  // next-state for all writable registers
  always_comb begin
    inh_d   = inh_q;
    enc_d   = enc_q;
    rat_d   = rat_q;
    bk_lo_d = bk_lo_q;
    bk_hi_d = bk_hi_q;
    pk_d    = pk_q;
    ck_d    = ck_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    vld_d   = vld_q;
    if (cfg_wr) begin
      if (hit_ofs(cfg_addr, OFS_CTRL)) begin
        inh_d = cfg_wdata[0];
        enc_d = cfg_wdata[1];
      end
      if (hit_ofs(cfg_addr, OFS_RATCHET) && (rat_q != RW'(RATCHET_MAX)))
        rat_d = rat_q + 1'b1;
      if (hit_ofs(cfg_addr, OFS_BKEY_LO)) bk_lo_d = cfg_wdata;
      if (hit_ofs(cfg_addr, OFS_BKEY_HI)) bk_hi_d = cfg_wdata;
      if (hit_ofs(cfg_addr, OFS_PASS_LO)) pk_d[DATA_W-1:0] = cfg_wdata;
      if (hit_ofs(cfg_addr, OFS_PASS_HI)) pk_d[KEY_W-1:DATA_W] = cfg_wdata[KHI_W-1:0];
      if (hit_ofs(cfg_addr, OFS_CARD_LO)) ck_d[DATA_W-1:0] = cfg_wdata;
      if (hit_ofs(cfg_addr, OFS_CARD_HI)) ck_d[KEY_W-1:DATA_W] = cfg_wdata[KHI_W-1:0];
      for (int i = 0; i < N_WIN; i++) begin
        if (hit_ofs(cfg_addr, WIN_BASE + 2*i)) begin
          lo_d[i]  = cfg_wdata[ADDR_W-1:0];
          vld_d[i] = cfg_wdata[DATA_W-1];
        end
        if (hit_ofs(cfg_addr, WIN_BASE + 2*i + 1))
          hi_d[i] = cfg_wdata[ADDR_W-1:0];
      end
    end
  end

  // readback selection
  always_comb begin
    rd_val = '0;
    if (hit_ofs(cfg_addr, OFS_CTRL))    rd_val = {{(DATA_W-2){1'b0}}, enc_q, inh_q};
    if (hit_ofs(cfg_addr, OFS_RATCHET)) rd_val = {{(DATA_W-RW){1'b0}}, rat_q};
    if (hit_ofs(cfg_addr, OFS_BKEY_LO)) rd_val = bk_lo_q;
    if (hit_ofs(cfg_addr, OFS_BKEY_HI)) rd_val = bk_hi_q;
    if (hit_ofs(cfg_addr, OFS_PASS_LO)) rd_val = pk_q[DATA_W-1:0];
    if (hit_ofs(cfg_addr, OFS_PASS_HI)) rd_val = {{(2*DATA_W-KEY_W){1'b0}}, pk_q[KEY_W-1:DATA_W]};
    if (hit_ofs(cfg_addr, OFS_CARD_LO)) rd_val = ck_q[DATA_W-1:0];
    if (hit_ofs(cfg_addr, OFS_CARD_HI)) rd_val = {{(2*DATA_W-KEY_W){1'b0}}, ck_q[KEY_W-1:DATA_W]};
    for (int i = 0; i < N_WIN; i++) begin
      if (hit_ofs(cfg_addr, WIN_BASE + 2*i))
        rd_val = {vld_q[i], {(DATA_W-1-ADDR_W){1'b0}}, lo_q[i]};
      if (hit_ofs(cfg_addr, WIN_BASE + 2*i + 1))
        rd_val = {{(DATA_W-ADDR_W){1'b0}}, hi_q[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q   <= 1'b1;
      enc_q   <= 1'b0;
      rat_q   <= '0;
      bk_lo_q <= '0;
      bk_hi_q <= '0;
      pk_q    <= '0;
      ck_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      vld_q   <= '0;
      rdata_q <= '0;
    end else begin
      inh_q   <= inh_d;
      enc_q   <= enc_d;
      rat_q   <= rat_d;
      bk_lo_q <= bk_lo_d;
      bk_hi_q <= bk_hi_d;
      pk_q    <= pk_d;
      ck_q    <= ck_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      vld_q   <= vld_d;
      if (cfg_rd) rdata_q <= rd_val;
    end
  end

  assign cfg_rdata = rdata_q;
  assign inhibit   = inh_q;
  assign enc_en    = enc_q;
  assign pass_key  = pk_q;
  assign card_key  = ck_q;
  assign win_lo    = lo_q;
  assign win_hi    = hi_q;
  assign win_vld   = vld_q;

  // R7
  ratchet_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rat_q <= RW'(RATCHET_MAX));

  // R7
  ratchet_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rat_q != $past(rat_q)) |-> (rat_q == $past(rat_q) + 1'b1));
endmodule

// File: rtl/slt_link_fsm.sv
module slt_link_fsm
  import slt_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_start,
  input  logic              up_wr,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [BEAT_W-1:0] up_wbyte,
  output logic              up_rvalid,
  output logic [BEAT_W-1:0] up_rbyte,
  output logic              up_ack,
  output logic              up_busy,
  input  logic              permit,
  input  logic              enc_en,
  input  logic [DATA_W-1:0] key_mask,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_read,
  output logic              dn_write,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_wait
);
  localparam int CW = $clog2(BEATS);
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  link_st_e          st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              wr_q, wr_d;
  logic              held_q, held_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wbuf_q, wbuf_d, rbuf_q, rbuf_d;
  logic [DATA_W-1:0] eff_mask;
  logic              go;

  assign eff_mask = enc_en ? key_mask : '0;
  // once a request is waiting it stays committed even if the policy moves
  assign go       = (st_q == ST_ISSUE) && (permit || held_q);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    held_d = held_q;
    addr_d = addr_q;
    wbuf_d = wbuf_q;
    rbuf_d = rbuf_q;
    unique case (st_q)
      ST_IDLE: begin
        if (up_start) begin
          addr_d = up_addr;
          wr_d   = up_wr;
          cnt_d  = '0;
          st_d   = up_wr ? ST_GATHER : ST_ISSUE;
        end
      end
      ST_GATHER: begin
        wbuf_d = {up_wbyte, wbuf_q[DATA_W-1:BEAT_W]};
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) st_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (!go) begin
          rbuf_d = '0;
          cnt_d  = '0;
          st_d   = wr_q ? ST_ACK : ST_RESP;
        end else if (dn_wait) begin
          held_d = 1'b1;
        end else begin
          rbuf_d = dn_rdata ^ eff_mask;
          held_d = 1'b0;
          cnt_d  = '0;
          st_d   = wr_q ? ST_ACK : ST_RESP;
        end
      end
      ST_RESP: begin
        rbuf_d = rbuf_q >> BEAT_W;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) st_d = ST_ACK;
      end
      ST_ACK:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      held_q <= 1'b0;
      addr_q <= '0;
      wbuf_q <= '0;
      rbuf_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      held_q <= held_d;
      addr_q <= addr_d;
      wbuf_q <= wbuf_d;
      rbuf_q <= rbuf_d;
    end
  end

  assign dn_addr   = addr_q;
  assign dn_read   = go && !wr_q;
  assign dn_write  = go && wr_q;
  assign dn_wdata  = wbuf_q ^ eff_mask;
  assign up_rvalid = (st_q == ST_RESP);
  assign up_rbyte  = rbuf_q[BEAT_W-1:0];
  assign up_ack    = (st_q == ST_ACK);
  assign up_busy   = (st_q != ST_IDLE);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dn_read || dn_write) && dn_wait) |=>
      ((dn_read || dn_write) && $stable(dn_addr) && $stable(dn_write)));

  // R2
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_read && dn_write));

  // R1
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack |=> (!up_ack && !up_rvalid));
endmodule

// File: rtl/slt_gate.sv
module slt_gate
  import slt_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int N_WIN       = 4,
  parameter int RATCHET_MAX = 8,
  parameter int CFG_AW      = $clog2(WIN_BASE + 2*N_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_start,
  input  logic              up_wr,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [7:0]        up_wbyte,
  output logic              up_rvalid,
  output logic [7:0]        up_rbyte,
  output logic              up_ack,
  output logic              up_busy,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_read,
  output logic              dn_write,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata,
  input  logic              dn_wait,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);
  logic                         inhibit, enc_en, win_hit;
  logic [KEY_W-1:0]             pass_key, card_key;
  logic [N_WIN-1:0][ADDR_W-1:0] win_lo, win_hi;
  logic [N_WIN-1:0]             win_vld;

  slt_cfg_regs #(
    .ADDR_W(ADDR_W), .N_WIN(N_WIN), .RATCHET_MAX(RATCHET_MAX), .CFG_AW(CFG_AW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .inhibit(inhibit), .enc_en(enc_en),
    .pass_key(pass_key), .card_key(card_key),
    .win_lo(win_lo), .win_hi(win_hi), .win_vld(win_vld)
  );

  slt_window_match #(.ADDR_W(ADDR_W), .N_WIN(N_WIN)) u_match (
    .addr(dn_addr), .win_lo(win_lo), .win_hi(win_hi), .win_vld(win_vld),
    .hit(win_hit)
  );

  slt_link_fsm #(.ADDR_W(ADDR_W)) u_link (
    .clk(clk), .rst_n(rst_n),
    .up_start(up_start), .up_wr(up_wr), .up_addr(up_addr), .up_wbyte(up_wbyte),
    .up_rvalid(up_rvalid), .up_rbyte(up_rbyte), .up_ack(up_ack), .up_busy(up_busy),
    .permit(win_hit && !inhibit), .enc_en(enc_en),
    .key_mask(mix_mask(pass_key, card_key)),
    .dn_addr(dn_addr), .dn_read(dn_read), .dn_write(dn_write),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_wait(dn_wait)
  );

  // R5
  inhibit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_read || dn_write) |-> !inhibit);

  // R3
  window_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_read || dn_write) |-> win_hit);
endmodule

// File: tb/sim_slt_gate.sv
module sim_slt_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_start = 1'b0, up_wr = 1'b0;
  logic [23:0] up_addr = '0;
  logic [7:0]  up_wbyte = '0;
  logic        up_rvalid, up_ack, up_busy;
  logic [7:0]  up_rbyte;
  logic [23:0] dn_addr;
  logic        dn_read, dn_write, dn_wait;
  logic [31:0] dn_wdata, dn_rdata;
  logic [3:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int checks = 0, errors = 0, cyc = 0;
  int wait_cycles = 0, wcnt = 0, dn_cnt = 0;
  logic        expect_dn = 1'b0;
  logic [23:0] last_a = '0;
  logic [31:0] last_d = '0;
  logic        last_w = 1'b0;

  // reference state of the configuration side
  logic        m_inh, m_enc;
  int          m_rat;
  logic [31:0] m_bk0, m_bk1;
  logic [47:0] m_pk, m_ck;
  logic [23:0] m_lo[4], m_hi[4];
  logic        m_v[4];

  slt_gate u0 (
    .clk(clk), .rst_n(rst_n),
    .up_start(up_start), .up_wr(up_wr), .up_addr(up_addr), .up_wbyte(up_wbyte),
    .up_rvalid(up_rvalid), .up_rbyte(up_rbyte), .up_ack(up_ack), .up_busy(up_busy),
    .dn_addr(dn_addr), .dn_read(dn_read), .dn_write(dn_write),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_wait(dn_wait),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  always #2 clk = ~clk;

  // downstream stub: fixed wait count, data derived from the address
  assign dn_wait  = (dn_read || dn_write) && (wcnt < wait_cycles);
  assign dn_rdata = {dn_addr[7:0], dn_addr} ^ 32'hC3A5_0F96;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= 0;
    else if (dn_read || dn_write) wcnt <= dn_wait ? wcnt + 1 : 0;
  end

  always @(posedge clk) begin
    if (rst_n && (dn_read || dn_write) && !dn_wait) begin
      dn_cnt <= dn_cnt + 1;
      last_a <= dn_addr;
      last_d <= dn_wdata;
      last_w <= dn_write;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference decision
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 downstream request only when model allows",
          {31'b0, (dn_read || dn_write) && !expect_dn}, 32'h0);
      chk("R2 ack and byte beat exclusive", {31'b0, up_ack && up_rvalid}, 32'h0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=60000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] m_mask();
    return m_enc ? {m_pk[47:44], m_ck[47:44], m_pk[43:40], m_ck[43:40],
                    m_pk[7:4], m_ck[7:4], m_pk[3:0], m_ck[3:0]} : 32'h0;
  endfunction

  function automatic logic m_allowed(input logic [23:0] a);
    logic ok = 1'b0;
    for (int i = 0; i < 4; i++)
      if (m_v[i] && a >= m_lo[i] && a <= m_hi[i]) ok = 1'b1;
    return ok && !m_inh;
  endfunction

  function automatic logic [31:0] m_read(input int a);
    case (a)
      0: return {30'b0, m_enc, m_inh};
      1: return 32'(m_rat);
      2: return m_bk0;
      3: return m_bk1;
      4: return m_pk[31:0];
      5: return {16'b0, m_pk[47:32]};
      6: return m_ck[31:0];
      7: return {16'b0, m_ck[47:32]};
      default: begin
        if (a % 2 == 0) return {m_v[(a-8)/2], 7'b0, m_lo[(a-8)/2]};
        return {8'b0, m_hi[(a-8)/2]};
      end
    endcase
  endfunction

  task automatic m_reset();
    m_inh = 1'b1; m_enc = 1'b0; m_rat = 0;
    m_bk0 = '0; m_bk1 = '0; m_pk = '0; m_ck = '0;
    for (int i = 0; i < 4; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_v[i] = 1'b0; end
  endtask

  task automatic cfg_w(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    case (a)
      0: begin m_inh = d[0]; m_enc = d[1]; end
      1: if (m_rat < 8) m_rat++;
      2: m_bk0 = d;
      3: m_bk1 = d;
      4: m_pk[31:0] = d;
      5: m_pk[47:32] = d[15:0];
      6: m_ck[31:0] = d;
      7: m_ck[47:32] = d[15:0];
      default: begin
        if (a % 2 == 0) begin m_lo[(a-8)/2] = d[23:0]; m_v[(a-8)/2] = d[31]; end
        else m_hi[(a-8)/2] = d[23:0];
      end
    endcase
  endtask

  task automatic cfg_r(input int a, input string tag);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = 4'(a);
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(tag, cfg_rdata, m_read(a));
  endtask

  task automatic do_read(input logic [23:0] a, input int w, input string tag);
    logic        ok = m_allowed(a);
    logic [31:0] exp_word = ok ? (({a[7:0], a} ^ 32'hC3A5_0F96) ^ m_mask()) : 32'h0;
    logic [31:0] word = '0;
    int first = 0, ackn = 0, beats = 0, base = dn_cnt;
    wait_cycles = w;
    expect_dn = ok;
    @(negedge clk);
    up_start = 1'b1; up_wr = 1'b0; up_addr = a;
    for (int n = 1; n < 40; n++) begin
      @(negedge clk);
      up_start = 1'b0;
      if (up_rvalid) begin
        if (first == 0) first = n;
        if (beats < 4) word[beats*8 +: 8] = up_rbyte;
        beats++;
      end
      if (up_ack) begin ackn = n; break; end
    end
    expect_dn = 1'b0;
    chk({tag, " R2 read word"}, word, exp_word);
    chk({tag, " R2/R4 first byte cycle"}, 32'(first), 32'(ok ? w + 2 : 2));
    chk({tag, " R2 ack cycle"}, 32'(ackn), 32'(first + 4));
    chk({tag, " R4 downstream count"}, 32'(dn_cnt - base), 32'(ok ? 1 : 0));
    if (ok) chk({tag, " R10 read address"}, {8'b0, last_a}, {8'b0, a});
  endtask

  task automatic do_write(input logic [23:0] a, input logic [31:0] d, input int w,
                          input string tag);
    logic ok = m_allowed(a);
    logic [31:0] exp_d = d ^ m_mask();
    int ackn = 0, base = dn_cnt;
    wait_cycles = w;
    expect_dn = ok;
    @(negedge clk);
    up_start = 1'b1; up_wr = 1'b1; up_addr = a;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      up_start = 1'b0;
      up_wbyte = d[b*8 +: 8];
    end
    for (int n = 5; n < 40; n++) begin
      @(negedge clk);
      if (up_ack) begin ackn = n; break; end
    end
    expect_dn = 1'b0;
    chk({tag, " R1/R4 write ack cycle"}, 32'(ackn), 32'(ok ? 6 + w : 6));
    chk({tag, " R4 downstream count"}, 32'(dn_cnt - base), 32'(ok ? 1 : 0));
    if (ok) begin
      chk({tag, " R1 write address"}, {8'b0, last_a}, {8'b0, a});
      chk({tag, " R1/R6 write data"}, last_d, exp_d);
      chk({tag, " R1 write direction"}, {31'b0, last_w}, 32'h1);
    end
  endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: every register at its reset value
    for (int a = 0; a < 16; a++) cfg_r(a, "R9 reset readback");
    chk("R9 idle after reset", {30'b0, up_busy, up_ack}, 32'h0);

    // R5: blocked from reset even with a window open
    do_read(24'h000100, 0, "R5 blocked read");
    cfg_w(8, 32'h8000_1000);
    cfg_w(9, 32'h0000_1FFF);
    do_write(24'h001004, 32'hDEAD_BEEF, 0, "R5 blocked write");
    cfg_w(12, 32'h8008_0000);
    cfg_w(13, 32'h0008_00FF);
    cfg_w(10, 32'h0000_5000);
    cfg_w(11, 32'h0000_5FFF);
    for (int a = 8; a < 14; a++) cfg_r(a, "R3 window readback");
    cfg_w(0, 32'h0);
    cfg_r(0, "R5 control readback");

    // R1/R3: lower bound inclusive, no wait
    do_write(24'h001000, 32'h1234_5678, 0, "R3 low bound");
    // R2/R10: upper bound inclusive with wait states
    do_read(24'h001FFF, 3, "R3 high bound");
    do_read(24'h002000, 0, "R3 above high");
    do_read(24'h000FFF, 0, "R3 below low");
    do_read(24'h080010, 1, "R3 second window");
    do_write(24'h080020, 32'hA5A5_0001, 4, "R10 write wait");
    do_read(24'h005010, 0, "R3 disabled window");
    do_write(24'h005010, 32'h0000_0001, 0, "R3 disabled window");

    // R6: keys and encryption
    cfg_w(4, 32'h89AB_CDEF);
    cfg_w(5, 32'h0000_4567);
    cfg_w(6, 32'h1357_9BDF);
    cfg_w(7, 32'h0000_2468);
    for (int a = 4; a < 8; a++) cfg_r(a, "R8 key readback");
    cfg_w(0, 32'h2);
    cfg_r(0, "R6 control readback");
    do_write(24'h001100, 32'hCAFE_F00D, 2, "R6 masked write");
    do_read(24'h001200, 0, "R6 masked read");
    do_read(24'h003000, 0, "R6 denied read stays zero");

    // R5: block set again mid-run
    cfg_w(0, 32'h3);
    do_read(24'h001200, 0, "R5 reblocked read");

    // R8: board key
    cfg_w(2, 32'h0F1E_2D3C);
    cfg_w(3, 32'h4B5A_6978);
    cfg_r(2, "R8 board key low");
    cfg_r(3, "R8 board key high");

    // R7: ratchet climbs by one per write, whatever the data, then holds
    for (int k = 0; k < 10; k++) begin
      cfg_w(1, 32'(k * 3));
      cfg_r(1, "R7 ratchet value");
    end

    // R7/R9: only reset lowers it, and the policy closes again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_reset();
    cfg_r(1, "R7 ratchet after reset");
    cfg_r(0, "R9 control after reset");
    cfg_r(8, "R9 window after reset");
    cfg_r(4, "R9 key after reset");
    do_read(24'h001000, 0, "R9 denied after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule